// File: doc/BRIEF.md
# Asynchronous Static Memory Access Sequencer

This block runs one access to an asynchronous SRAM or NOR-type device at a time. It counts every phase in system clock cycles and never drives a clock to the memory. When it is idle and a request arrives, it latches the request: direction, chip-select index, byte address, write data and the mode settings. It then steps through an address-setup phase, an optional address-hold phase and a data phase. A write also gets a forced write-hold cycle. A read on a multiplexed bus may also get a bus turnaround gap. When the memory controls are back at rest, the block pulses `done_o`.

Two waveform styles are available. The SRAM style drives only chip enable, output enable and write enable. The NOR style also pulses an active-low address-valid strobe during address setup. The extended option has two effects. Output enable is then confined to the data phase of a read. Writes take their timing from a separate write set, while reads keep the read set; with the option off, the read set times both directions. The multiplexed option has three effects. The low address bits go onto the data bus during the setup and hold phases. Output enable is held back until the data phase. A programmable all-high gap follows every read before the next access can start.

The data bus is split into output, output-enable and input so that the pad ring can build the tri-state buffer. Read data is sampled on the clock edge that ends the data phase, while chip enable is still low, so the memory needs no hold time after chip enable rises.

Top module: `smem_timer`

## Requirements
- R1: After reset and in every idle cycle (including the cycle where `done_o` is high), all chip enables, output enable, write enable and the address-valid strobe are high, and `mem_data_oe_o` is low.
- R2: During an access exactly one chip enable is low: bit `req_cs_i` as latched at acceptance. The others stay high.
- R3: A read keeps chip enable low for setup + hold + data cycles. A data-phase count of 0 is treated as 1.
- R4: `rdata_o` takes the value on `mem_data_i` in the last data-phase cycle of a read. It changes only on the edge where chip enable rises.
- R5: A write keeps write enable low for the data-phase count (0 treated as 1). It then holds one extra cycle with write enable high and chip enable low, with address and write data unchanged. Chip enable is low for setup + hold + data + 1 cycles.
- R6: Without the extended or multiplexed option, output enable is low for the whole read access. With either option, it is low only during the data phase. It is never low during a write.
- R7: In NOR style, the address-valid strobe is low for exactly the setup-phase cycles. In SRAM style it never goes low.
- R8: With the extended option off, writes use the read timing set. With it on, writes use the write timing set and reads keep the read set.
- R9: On a multiplexed bus, `mem_data_o` carries address bits [DATA_W-1:0] with `mem_data_oe_o` high during setup and hold. A read is then followed by turnaround-count idle cycles before `done_o`. On a non-multiplexed bus the turnaround count has no effect.
- R10: `done_o` is a one-cycle pulse. A request is accepted in any idle cycle, including the `done_o` cycle. A request raised while an access is in progress is ignored.
- R11: Write enable and output enable are never low together, and the block never drives the data bus while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start an access (taken only when idle) |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_cs_i | input | CS_W | Chip-select index |
| req_addr_i | input | ADDR_W | Memory address |
| req_wdata_i | input | DATA_W | Write data |
| cfg_nor_i | input | 1 | NOR style with address-valid strobe |
| cfg_ext_i | input | 1 | Extended option: separate write timing, narrow output enable |
| cfg_mux_i | input | 1 | Address/data multiplexed bus |
| rd_setup_i | input | CNT_W | Read-set address-setup cycles |
| rd_hold_i | input | CNT_W | Read-set address-hold cycles |
| rd_dphase_i | input | CNT_W | Read-set data-phase cycles (0 acts as 1) |
| rd_turn_i | input | CNT_W | Turnaround cycles after a multiplexed read |
| wr_setup_i | input | CNT_W | Write-set address-setup cycles |
| wr_hold_i | input | CNT_W | Write-set address-hold cycles |
| wr_dphase_i | input | CNT_W | Write-set data-phase cycles (0 acts as 1) |
| mem_ce_n_o | output | NUM_CS | Chip enables, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_adv_n_o | output | 1 | Address-valid strobe, active low |
| mem_addr_o | output | ADDR_W | Address bus |
| mem_data_o | output | DATA_W | Data bus output value |
| mem_data_oe_o | output | 1 | Data bus output enable |
| mem_data_i | input | DATA_W | Data bus input value |
| rdata_o | output | DATA_W | Captured read data |
| done_o | output | 1 | Access complete pulse |

## Verification
The assertions check the properties that hold every cycle. At most one chip enable is low. Write and output enable never overlap, and the bus is never driven against the memory. Write enable and the strobe appear only inside an access. Every rising edge of write enable is followed by a cycle with chip enable still low and address and data held. Read data changes only as chip enable rises. `done_o` lasts one cycle and comes with idle controls. Only the bench scenarios can show the phase lengths. These cover:
- which timing set is chosen for each mode combination;
- the clamping of a zero data-phase count;
- the address on a multiplexed bus and the turnaround gap;
- the value captured from the memory;
- a request raised mid-access being dropped, and a request raised in the done cycle starting at once.

// File: rtl/smem_pkg.sv
package smem_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_HOLD  = 3'd2,
    PH_DATA  = 3'd3,
    PH_WHOLD = 3'd4,
    PH_TURN  = 3'd5
  } phase_e;

  typedef struct packed {
    logic nor_style;
    logic ext;
    logic mux;
  } mode_t;

endpackage

// File: rtl/smem_tsel.sv
// Picks the active timing set for a new request and normalises the counts.
module smem_tsel #(
  parameter int CNT_W = 4
) (
  input  logic             we_i,
  input  logic             ext_i,
  input  logic             mux_i,
  input  logic [CNT_W-1:0] rd_setup_i,
  input  logic [CNT_W-1:0] rd_hold_i,
  input  logic [CNT_W-1:0] rd_dphase_i,
  input  logic [CNT_W-1:0] rd_turn_i,
  input  logic [CNT_W-1:0] wr_setup_i,
  input  logic [CNT_W-1:0] wr_hold_i,
  input  logic [CNT_W-1:0] wr_dphase_i,
  output logic [CNT_W-1:0] setup_o,
  output logic [CNT_W-1:0] hold_o,
  output logic [CNT_W-1:0] dphase_o,
  output logic [CNT_W-1:0] turn_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             use_wr;
  logic [CNT_W-1:0] dph_raw;

  assign use_wr  = we_i && ext_i;
  assign setup_o = use_wr ? wr_setup_i : rd_setup_i;
  assign hold_o  = use_wr ? wr_hold_i  : rd_hold_i;
  assign dph_raw = use_wr ? wr_dphase_i : rd_dphase_i;
  // write-hold cycle needs a data phase of at least one cycle
  assign dphase_o = (dph_raw == '0) ? ONE : dph_raw;
  // turnaround only protects a multiplexed bus after a read
  assign turn_o   = (mux_i && !we_i) ? rd_turn_i : '0;

endmodule

// File: rtl/smem_phase.sv
// Phase sequencer: setup -> hold -> data -> (write hold | turnaround) -> idle.
module smem_phase
  import smem_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] setup_i,
  input  logic [CNT_W-1:0] hold_i,
  input  logic [CNT_W-1:0] dphase_i,
  input  logic [CNT_W-1:0] turn_i,
  output phase_e           phase_o,
  output logic             capture_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] hold_q, dph_q, turn_q;
  logic             we_q;
  logic             done_q, done_d;
  logic             last;

  assign last = (cnt_q == '0);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          if (setup_i != '0) begin
            ph_d  = PH_SETUP;
            cnt_d = setup_i - ONE;
          end else if (hold_i != '0) begin
            ph_d  = PH_HOLD;
            cnt_d = hold_i - ONE;
          end else begin
            ph_d  = PH_DATA;
            cnt_d = dphase_i - ONE;
          end
        end
      end
      PH_SETUP: begin
        if (!last) begin
          cnt_d = cnt_q - ONE;
        end else if (hold_q != '0) begin
          ph_d  = PH_HOLD;
          cnt_d = hold_q - ONE;
        end else begin
          ph_d  = PH_DATA;
          cnt_d = dph_q - ONE;
        end
      end
      PH_HOLD: begin
        if (!last) begin
          cnt_d = cnt_q - ONE;
        end else begin
          ph_d  = PH_DATA;
          cnt_d = dph_q - ONE;
        end
      end
      PH_DATA: begin
        if (!last) begin
          cnt_d = cnt_q - ONE;
        end else if (we_q) begin
          ph_d  = PH_WHOLD;
          cnt_d = '0;
        end else if (turn_q != '0) begin
          ph_d  = PH_TURN;
          cnt_d = turn_q - ONE;
        end else begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end
      end
      PH_WHOLD: begin
        ph_d   = PH_IDLE;
        done_d = 1'b1;
      end
      PH_TURN: begin
        if (!last) begin
          cnt_d = cnt_q - ONE;
        end else begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      dph_q  <= '0;
      turn_q <= '0;
      we_q   <= 1'b0;
    end else if (start_i && ph_q == PH_IDLE) begin
      hold_q <= hold_i;
      dph_q  <= dphase_i;
      turn_q <= turn_i;
      we_q   <= we_i;
    end
  end

  assign phase_o   = ph_q;
  assign capture_o = (ph_q == PH_DATA) && last && !we_q;
  assign done_o    = done_q;

endmodule

// File: rtl/smem_pins.sv
// Decodes memory pin levels from the registered phase and latched request.
module smem_pins
  import smem_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int NUM_CS = 4,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  phase_e            phase_i,
  input  mode_t             mode_i,
  input  logic              we_i,
  input  logic [CS_W-1:0]   cs_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NUM_CS-1:0] ce_n_o,
  output logic              oe_n_o,
  output logic              we_n_o,
  output logic              adv_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);

  logic act;
  logic addr_ph;
  logic oe_wide;

  assign act     = (phase_i == PH_SETUP) || (phase_i == PH_HOLD) ||
                   (phase_i == PH_DATA)  || (phase_i == PH_WHOLD);
  assign addr_ph = (phase_i == PH_SETUP) || (phase_i == PH_HOLD);
  assign oe_wide = !mode_i.ext && !mode_i.mux;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ce
    assign ce_n_o[g] = !(act && (cs_i == CS_W'(g)));
  end

  assign oe_n_o    = !(!we_i && ((phase_i == PH_DATA) || (oe_wide && addr_ph)));
  assign we_n_o    = !(we_i && (phase_i == PH_DATA));
  assign adv_n_o   = !(mode_i.nor_style && (phase_i == PH_SETUP));
  assign data_oe_o = act && (we_i || (mode_i.mux && addr_ph));
  assign data_o    = (mode_i.mux && addr_ph) ? addr_i[DATA_W-1:0] : wdata_i;
  assign addr_o    = addr_i;

endmodule

// File: rtl/smem_timer.sv
module smem_timer
  import smem_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int NUM_CS = 4,
  parameter int CNT_W  = 4,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [CS_W-1:0]   req_cs_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              cfg_nor_i,
  input  logic              cfg_ext_i,
  input  logic              cfg_mux_i,
  input  logic [CNT_W-1:0]  rd_setup_i,
  input  logic [CNT_W-1:0]  rd_hold_i,
  input  logic [CNT_W-1:0]  rd_dphase_i,
  input  logic [CNT_W-1:0]  rd_turn_i,
  input  logic [CNT_W-1:0]  wr_setup_i,
  input  logic [CNT_W-1:0]  wr_hold_i,
  input  logic [CNT_W-1:0]  wr_dphase_i,
  output logic [NUM_CS-1:0] mem_ce_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic              mem_adv_n_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              mem_data_oe_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);

  phase_e            phase;
  logic              start;
  logic              capture;
  logic [CNT_W-1:0]  t_setup, t_hold, t_dph, t_turn;

  logic              we_q;
  logic [CS_W-1:0]   cs_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  mode_t             mode_q;
  logic [DATA_W-1:0] rdata_q;

  assign start = req_i && (phase == PH_IDLE);

  smem_tsel #(.CNT_W(CNT_W)) u_tsel (
    .we_i        (req_we_i),
    .ext_i       (cfg_ext_i),
    .mux_i       (cfg_mux_i),
    .rd_setup_i  (rd_setup_i),
    .rd_hold_i   (rd_hold_i),
    .rd_dphase_i (rd_dphase_i),
    .rd_turn_i   (rd_turn_i),
    .wr_setup_i  (wr_setup_i),
    .wr_hold_i   (wr_hold_i),
    .wr_dphase_i (wr_dphase_i),
    .setup_o     (t_setup),
    .hold_o      (t_hold),
    .dphase_o    (t_dph),
    .turn_o      (t_turn)
  );

  smem_phase #(.CNT_W(CNT_W)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .we_i      (req_we_i),
    .setup_i   (t_setup),
    .hold_i    (t_hold),
    .dphase_i  (t_dph),
    .turn_i    (t_turn),
    .phase_o   (phase),
    .capture_o (capture),
    .done_o    (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      cs_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      mode_q  <= '0;
    end else if (start) begin
      we_q    <= req_we_i;
      cs_q    <= req_cs_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      mode_q  <= '{nor_style: cfg_nor_i, ext: cfg_ext_i, mux: cfg_mux_i};
    end
  end

  // sampled on the edge that ends the data phase, chip enable still low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (capture) rdata_q <= mem_data_i;
  end
  assign rdata_o = rdata_q;

  smem_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_CS (NUM_CS)
  ) u_pins (
    .phase_i   (phase),
    .mode_i    (mode_q),
    .we_i      (we_q),
    .cs_i      (cs_q),
    .addr_i    (addr_q),
    .wdata_i   (wdata_q),
    .ce_n_o    (mem_ce_n_o),
    .oe_n_o    (mem_oe_n_o),
    .we_n_o    (mem_we_n_o),
    .adv_n_o   (mem_adv_n_o),
    .addr_o    (mem_addr_o),
    .data_o    (mem_data_o),
    .data_oe_o (mem_data_oe_o)
  );

endmodule

// File: rtl/smem_timer_chk.sv
module smem_timer_chk #(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int NUM_CS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CS-1:0] mem_ce_n_o,
  input logic              mem_oe_n_o,
  input logic              mem_we_n_o,
  input logic              mem_adv_n_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_data_o,
  input logic              mem_data_oe_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              done_o
);

  logic ce_idle;
  assign ce_idle = &mem_ce_n_o;

  p_ce_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_ce_n_o));

  p_we_oe_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_we_n_o && !mem_oe_n_o));

  p_bus_oe_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_data_oe_o && !mem_oe_n_o));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ce_idle && mem_we_n_o && mem_oe_n_o && mem_adv_n_o && !mem_data_oe_o));

  p_write_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (!ce_idle && mem_data_oe_o && $stable(mem_addr_o) && $stable(mem_data_o)));

  p_we_in_access_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> !ce_idle);

  p_adv_in_access_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_adv_n_o |-> !ce_idle);

  p_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> $rose(ce_idle));

endmodule

bind smem_timer smem_timer_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .NUM_CS (NUM_CS)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mem_ce_n_o    (mem_ce_n_o),
  .mem_oe_n_o    (mem_oe_n_o),
  .mem_we_n_o    (mem_we_n_o),
  .mem_adv_n_o   (mem_adv_n_o),
  .mem_addr_o    (mem_addr_o),
  .mem_data_o    (mem_data_o),
  .mem_data_oe_o (mem_data_oe_o),
  .rdata_o       (rdata_o),
  .done_o        (done_o)
);

// File: tb/smem_timer_tb.sv
module smem_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 26;
  localparam int DATA_W = 16;
  localparam int NUM_CS = 4;
  localparam int CNT_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              req = 1'b0, req_we = 1'b0;
  logic [1:0]        req_cs = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              c_nor = 1'b0, c_ext = 1'b0, c_mux = 1'b0;
  logic [CNT_W-1:0]  r_s = '0, r_h = '0, r_d = '0, r_t = '0;
  logic [CNT_W-1:0]  w_s = '0, w_h = '0, w_d = '0;

  logic [NUM_CS-1:0] ce_n;
  logic              oe_n, we_n, adv_n, d_oe, done;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] d_out, d_in, rdata;

  logic [DATA_W-1:0] mem [0:15];

  int checks = 0;
  int fails  = 0;

  smem_timer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS), .CNT_W(CNT_W)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_i(req), .req_we_i(req_we), .req_cs_i(req_cs),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .cfg_nor_i(c_nor), .cfg_ext_i(c_ext), .cfg_mux_i(c_mux),
    .rd_setup_i(r_s), .rd_hold_i(r_h), .rd_dphase_i(r_d), .rd_turn_i(r_t),
    .wr_setup_i(w_s), .wr_hold_i(w_h), .wr_dphase_i(w_d),
    .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n),
    .mem_adv_n_o(adv_n), .mem_addr_o(addr), .mem_data_o(d_out),
    .mem_data_oe_o(d_oe), .mem_data_i(d_in),
    .rdata_o(rdata), .done_o(done)
  );

  // memory model: drives when selected and output-enabled, stores on write-enable rise
  assign d_in = (!(&ce_n) && !oe_n) ? mem[addr[3:0]] : '0;

  always @(posedge we_n or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 16'hA500 + DATA_W'(i);
    end else if (!(&ce_n)) begin
      mem[addr[3:0]] <= d_out;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // one access; caller is at a negedge; returns at the done sample
  task automatic run(input logic we, input logic [1:0] cs, input logic [ADDR_W-1:0] a,
                     input logic [DATA_W-1:0] wd, input bit poke, input string tag);
    int s, h, d, t, exp_busy, exp_oe, exp_doe;
    int n = 0, n_ce = 0, n_we = 0, n_oe = 0, n_adv = 0, n_doe = 0, n_wh = 0;
    int bad_cs = 0, bad_x = 0, bad_bus = 0, bad_wh = 0;
    bit we_seen = 0;
    logic [DATA_W-1:0] exp_rd;
    s = (c_ext && we) ? int'(w_s) : int'(r_s);
    h = (c_ext && we) ? int'(w_h) : int'(r_h);
    d = (c_ext && we) ? int'(w_d) : int'(r_d);
    if (d == 0) d = 1;
    t = (!we && c_mux) ? int'(r_t) : 0;
    exp_busy = s + h + d + (we ? 1 : 0) + t;
    exp_oe   = we ? 0 : ((c_ext || c_mux) ? d : s + h + d);
    exp_doe  = we ? s + h + d + 1 : (c_mux ? s + h : 0);
    exp_rd   = mem[a[3:0]];
    req = 1'b1; req_we = we; req_cs = cs; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    chk(!(&ce_n), "R10", {tag, " accepted from idle"}, int'(&ce_n), 0);
    while (!done && n < 200) begin
      n++;
      if (!(&ce_n)) begin
        n_ce++;
        if (ce_n != ~(NUM_CS'(1) << cs)) bad_cs++;
        if (we_n && we_seen) begin
          n_wh++;
          if (d_out != wd || addr != a) bad_wh++;
        end
      end
      if (!we_n) begin n_we++; we_seen = 1; end
      if (!oe_n) n_oe++;
      if (!adv_n) n_adv++;
      if (d_oe) n_doe++;
      if (!we_n && !oe_n) bad_x++;
      if (d_oe && !oe_n) bad_x++;
      if (c_mux && !we && d_oe && d_out != a[DATA_W-1:0]) bad_bus++;
      if (poke && n == 1) begin
        req = 1'b1; req_cs = cs ^ 2'd1; req_addr = a ^ 'h3; req_we = ~we;
      end
      if (poke && n == 2) req = 1'b0;
      @(negedge clk);
    end
    chk(n == exp_busy, c_mux ? "R9" : (c_ext ? "R8" : (we ? "R5" : "R3")),
        {tag, " busy cycles"}, n, exp_busy);
    chk(n_ce == s + h + d + (we ? 1 : 0), we ? "R5" : "R3", {tag, " ce low cycles"},
        n_ce, s + h + d + (we ? 1 : 0));
    chk(n_we == (we ? d : 0), "R5", {tag, " we low cycles"}, n_we, we ? d : 0);
    chk(n_oe == exp_oe, "R6", {tag, " oe low cycles"}, n_oe, exp_oe);
    chk(n_adv == (c_nor ? s : 0), "R7", {tag, " adv low cycles"}, n_adv, c_nor ? s : 0);
    chk(n_doe == exp_doe && bad_bus == 0, "R9", {tag, " bus drive cycles"}, n_doe, exp_doe);
    chk(bad_cs == 0, "R2", {tag, " chip enable pattern"}, bad_cs, 0);
    chk(bad_x == 0, "R11", {tag, " oe/we/bus overlap"}, bad_x, 0);
    chk(ce_n == '1 && we_n && oe_n && adv_n && !d_oe, "R1", {tag, " idle at done"},
        int'({ce_n, we_n, oe_n, adv_n, d_oe}), 8'b11111110);
    if (we) begin
      chk(n_wh == 1 && bad_wh == 0, "R5", {tag, " write hold cycle"}, n_wh, 1);
      chk(mem[a[3:0]] == wd, "R5", {tag, " stored data"}, int'(mem[a[3:0]]), int'(wd));
    end else begin
      chk(rdata == exp_rd, "R4", {tag, " read data"}, int'(rdata), int'(exp_rd));
    end
  endtask

  task automatic t_reset();
    chk(ce_n == '1 && we_n && oe_n && adv_n && !d_oe && !done, "R1", "reset idle",
        int'({ce_n, we_n, oe_n, adv_n, d_oe, done}), 9'b111111100);
  endtask

  task automatic t_sram();
    c_nor = 0; c_ext = 0; c_mux = 0;
    r_s = 2; r_h = 1; r_d = 3; r_t = 5;
    w_s = 4; w_h = 4; w_d = 4;          // ignored: extended option off (R8)
    run(1, 2'd0, 26'h5, 16'h1234, 0, "sram wr");
    run(0, 2'd0, 26'h5, '0, 0, "sram rd");
    run(0, 2'd1, 26'h7, '0, 0, "sram rd2");
  endtask

  task automatic t_data_zero();
    c_nor = 0; c_ext = 0; c_mux = 0;
    r_s = 1; r_h = 0; r_d = 0;
    run(1, 2'd3, 26'h2, 16'hBEEF, 0, "dph0 wr");
    run(0, 2'd3, 26'h2, '0, 0, "dph0 rd");
  endtask

  task automatic t_ext();
    c_nor = 0; c_ext = 1; c_mux = 0;
    r_s = 1; r_h = 0; r_d = 2;
    w_s = 3; w_h = 1; w_d = 4;
    run(1, 2'd1, 26'h9, 16'h0F0F, 0, "ext wr");
    run(0, 2'd1, 26'h9, '0, 0, "ext rd");
    w_d = 0;
    run(1, 2'd1, 26'hA, 16'h5A5A, 0, "ext wr dph0");
  endtask

  task automatic t_nor();
    c_nor = 1; c_ext = 0; c_mux = 0;
    r_s = 3; r_h = 2; r_d = 2;
    run(0, 2'd2, 26'h3, '0, 0, "nor rd");
    run(1, 2'd2, 26'h3, 16'h7E57, 0, "nor wr");
    r_s = 0;
    run(0, 2'd2, 26'h3, '0, 0, "nor rd s0");
  endtask

  task automatic t_mux();
    c_nor = 1; c_ext = 0; c_mux = 1;
    r_s = 2; r_h = 2; r_d = 3; r_t = 3;
    run(1, 2'd0, 26'h2C_00B, 16'hC0DE, 0, "mux wr");
    run(0, 2'd0, 26'h2C_00B, '0, 0, "mux rd");
    r_t = 0;
    run(0, 2'd0, 26'h4, '0, 0, "mux rd t0");
  endtask

  task automatic t_busy();
    int idle_bad = 0;
    c_nor = 0; c_ext = 0; c_mux = 0;
    r_s = 2; r_h = 1; r_d = 2; r_t = 4;
    run(0, 2'd2, 26'h6, '0, 1, "poke rd");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (ce_n != '1 || done) idle_bad++;
    end
    chk(idle_bad == 0, "R10", "mid-access request dropped, single done", idle_bad, 0);
    run(0, 2'd2, 26'h6, '0, 0, "chain a");
    run(1, 2'd3, 26'h8, 16'h4321, 0, "chain b");
    run(0, 2'd3, 26'h8, '0, 0, "chain c");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "WD", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sram();
    t_data_zero();
    t_ext();
    t_nor();
    t_mux();
    t_busy();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule